// File: doc/BRIEF.md
# Audio Playback Sample Buffer with DMA Request

This block holds the samples that wait to be played on an audio DAC path. Samples arrive as 32-bit write beats from a register write or a DMA engine. Each beat carries one sample. The block widens the sample to 24 bits as it stores it, using the configured width and padding mode. A built-in rate divider produces a sample strobe from the module clock. At each strobe the block hands one left/right pair to the converter interface. In stereo the pair is two consecutive stored samples. In mono one stored sample feeds both channels.

A request line asks the DMA engine for more data. It works with two levels. It rises once the free space reaches the larger of the trigger level and the clear threshold. It falls once the free space drops below the clear threshold. If the buffer cannot supply a pair at a strobe, the block either sends silence or holds the last pair, and it raises a sticky underrun flag. A flush input empties the buffer and wins over a write in the same cycle, so software can flush and then re-enable requests safely.

The request logic is a three-state machine. DRQ_OFF is the state while requests are disabled. DRQ_WAIT means requests are enabled but there is not enough room. DRQ_REQ means the request is raised. The transitions are:
- enable: DRQ_OFF to DRQ_WAIT, when the enable bit is set.
- raise: DRQ_WAIT to DRQ_REQ, when the free space reaches the raise level.
- drop: DRQ_REQ to DRQ_WAIT, when the free space falls below the clear threshold.
- disable: any state to DRQ_OFF, when the enable bit is cleared.
- flush: any state goes to DRQ_WAIT or DRQ_OFF, following the enable bit.

Top module: `codec_tx_fifo`

## Requirements
- R1: A flush pulse makes fill read 0 on the next cycle. A write in the same cycle is dropped. The request machine restarts from DRQ_WAIT, or from DRQ_OFF if requests are disabled.
- R2: Free space is DEPTH (64) minus fill. The clear threshold is 2 << clr_cnt, so code 3 gives 16. dma_req rises one cycle after the free space reaches max(trig_lvl, clear threshold). Once raised, it falls one cycle after the free space drops below the clear threshold.
- R3: When drq_en is 0, dma_req is 0 from the next cycle. Stored data and fill are unchanged.
- R4: With wide_smp = 0, the sample is wr_data[15:0] and forms output bits [23:8]. Output bits [7:0] are copies of wr_data[15] when msb_rep = 1, and zeros when msb_rep = 0.
- R5: With wide_smp = 1, output bits [23:0] are wr_data[31:8]. wr_data[7:0] is ignored.
- R6: In stereo (mono = 0), a strobe takes two samples: the older goes to left_smp and the newer to right_smp. In mono a strobe takes one sample and puts it on both channels.
- R7: A strobe that finds fewer samples than it needs takes nothing. With und_repeat = 0 both outputs become 0. With und_repeat = 1 they keep the last pair. The strobe sets und_flag. An und_clr pulse clears und_flag, but a new underrun in the same cycle wins.
- R8: While play_en is 1, smp_stb pulses for one cycle every N cycles. N is BASE_DIV times the rate ratio for rate_code: 0:×1, 1:×1.5, 2:×2, 3:×3, 4:×4, 5:×6, 6:×1/4, 7:×1/2. While play_en is 0, smp_stb stays low.
- R9: A write while fill is DEPTH is dropped.
- R10: fill reports the number of stored samples. It never exceeds DEPTH and rises by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write beat valid |
| wr_data | input | 32 | Write beat carrying one sample |
| flush | input | 1 | Empty the buffer (one-cycle pulse) |
| drq_en | input | 1 | Allow DMA requests |
| trig_lvl | input | 6 | Free-space level that raises the request |
| clr_cnt | input | 2 | Clear threshold code (threshold = 2 << code) |
| wide_smp | input | 1 | 0: 16-bit samples, 1: 24 significant upper bits |
| msb_rep | input | 1 | 16-bit padding: 1 repeats the MSB, 0 fills zeros |
| und_repeat | input | 1 | Underrun output: 1 holds the last pair, 0 sends zeros |
| mono | input | 1 | One sample feeds both channels |
| rate_code | input | 3 | Sample rate selector |
| play_en | input | 1 | Run the sample strobe |
| und_clr | input | 1 | Clear the sticky underrun flag |
| dma_req | output | 1 | DMA request |
| smp_stb | output | 1 | New output pair valid (one cycle) |
| left_smp | output | 24 | Left output sample |
| right_smp | output | 24 | Right output sample |
| fill | output | 7 | Stored sample count |
| und_flag | output | 1 | Sticky underrun flag |

## Verification
The bench loads only one sample in stereo mode. A design that drains a lone sample would advance fill and put the wrong data on the right channel. The request is driven around the clear threshold, at free space 16 and then 15, and is checked when the free space is below the trigger level but the request is enabled. An off-by-one compare, or a design without the two-level rule, would show the wrong dma_req there. The padding checks use a sample with its MSB set, so a swapped or sign-blind pad shows up in the low byte. The strobe period is measured for three rate codes, so a wrong divider ratio appears as a wrong cycle count.

// File: rtl/codec_tx_pkg.sv
package codec_tx_pkg;

    typedef enum logic [1:0] {
        DRQ_OFF  = 2'd0,
        DRQ_WAIT = 2'd1,
        DRQ_REQ  = 2'd2
    } drq_state_t;

    // Strobe period in module clocks for a rate code.
    function automatic int rate_div(input int base, input logic [2:0] code);
        unique case (code)
            3'd0: rate_div = base;
            3'd1: rate_div = (base * 3) / 2;
            3'd2: rate_div = base * 2;
            3'd3: rate_div = base * 3;
            3'd4: rate_div = base * 4;
            3'd5: rate_div = base * 6;
            3'd6: rate_div = base / 4;
            default: rate_div = base / 2;
        endcase
    endfunction

endpackage

// File: rtl/codec_tx_rate_gen.sv
module codec_tx_rate_gen
    import codec_tx_pkg::*;
#(
    parameter int BASE_DIV = 512,
    localparam int CW = $clog2(BASE_DIV * 6 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate_code,
    output logic       tick
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;

    assign last_v = CW'(rate_div(BASE_DIV, rate_code) - 1);
    assign tick   = run && (cnt_q >= last_v);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/codec_tx_store.sv
module codec_tx_store #(
    parameter int DEPTH = 64,
    parameter int DW = 24,
    localparam int AW = $clog2(DEPTH),
    localparam int CNTW = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop_one,
    input  logic            pop_two,
    output logic [DW-1:0]   head0,
    output logic [DW-1:0]   head1,
    output logic [CNTW-1:0] count
);
    logic [DW-1:0]   mem_q [DEPTH];
    logic [AW-1:0]   wp_q;
    logic [AW-1:0]   rp_q;
    logic [CNTW-1:0] cnt_q;
    logic [AW-1:0]   rp_nx;
    logic [CNTW-1:0] pops;

    assign rp_nx = rp_q + 1'b1;
    assign head0 = mem_q[rp_q];
    assign head1 = mem_q[rp_nx];
    assign count = cnt_q;
    assign pops  = pop_two ? CNTW'(2) : (pop_one ? CNTW'(1) : CNTW'(0));

    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem_q[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wp_q <= wp_q + 1'b1;
            end
            rp_q  <= rp_q + AW'(pops);
            cnt_q <= cnt_q + CNTW'(push) - pops;
        end
    end
endmodule

// File: rtl/codec_tx_drq_fsm.sv
module codec_tx_drq_fsm
    import codec_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNTW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            flush,
    input  logic [CNTW-1:0] free,
    input  logic [5:0]      trig_lvl,
    input  logic [1:0]      clr_cnt,
    output logic            req
);
    drq_state_t      st_q;
    drq_state_t      st_d;
    logic [CNTW-1:0] clr_thr;
    logic [CNTW-1:0] trig_w;
    logic [CNTW-1:0] raise_lvl;

    assign clr_thr   = CNTW'(2) << clr_cnt;
    assign trig_w    = CNTW'(trig_lvl);
    assign raise_lvl = (trig_w > clr_thr) ? trig_w : clr_thr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DRQ_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = DRQ_OFF;
        end else if (flush) begin
            st_d = DRQ_WAIT;
        end else begin
            unique case (st_q)
                DRQ_OFF:  st_d = DRQ_WAIT;
                DRQ_WAIT: if (free >= raise_lvl) st_d = DRQ_REQ;
                DRQ_REQ:  if (free < clr_thr) st_d = DRQ_WAIT;
                default:  st_d = DRQ_OFF;
            endcase
        end
    end

    always_comb begin
        req = (st_q == DRQ_REQ);
    end
endmodule

// File: rtl/codec_tx_fifo.sv
module codec_tx_fifo
    import codec_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int BASE_DIV = 512,
    localparam int SW = 24,
    localparam int CNTW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [31:0]     wr_data,
    input  logic            flush,
    input  logic            drq_en,
    input  logic [5:0]      trig_lvl,
    input  logic [1:0]      clr_cnt,
    input  logic            wide_smp,
    input  logic            msb_rep,
    input  logic            und_repeat,
    input  logic            mono,
    input  logic [2:0]      rate_code,
    input  logic            play_en,
    input  logic            und_clr,
    output logic            dma_req,
    output logic            smp_stb,
    output logic [SW-1:0]   left_smp,
    output logic [SW-1:0]   right_smp,
    output logic [CNTW-1:0] fill,
    output logic            und_flag
);
    logic            tick;
    logic [SW-1:0]   wide_v;
    logic [SW-1:0]   head0;
    logic [SW-1:0]   head1;
    logic [CNTW-1:0] cnt;
    logic            push;
    logic            avail;
    logic            take;
    logic            starve;
    logic            stb_q;
    logic            und_q;
    logic [SW-1:0]   lq;
    logic [SW-1:0]   rq;

    // Expansion to the 24-bit stored form.
    always_comb begin
        if (wide_smp) begin
            wide_v = wr_data[31:8];
        end else if (msb_rep) begin
            wide_v = {wr_data[15:0], {8{wr_data[15]}}};
        end else begin
            wide_v = {wr_data[15:0], 8'h00};
        end
    end

    assign push   = wr_en && !flush && (cnt < CNTW'(DEPTH));
    assign avail  = mono ? (cnt >= CNTW'(1)) : (cnt >= CNTW'(2));
    assign take   = tick && avail && !flush;
    assign starve = tick && !take;

    codec_tx_rate_gen #(.BASE_DIV(BASE_DIV)) rate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (play_en),
        .rate_code (rate_code),
        .tick      (tick)
    );

    codec_tx_store #(.DEPTH(DEPTH), .DW(SW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push      (push),
        .push_data (wide_v),
        .pop_one   (take && mono),
        .pop_two   (take && !mono),
        .head0     (head0),
        .head1     (head1),
        .count     (cnt)
    );

    codec_tx_drq_fsm #(.DEPTH(DEPTH)) drq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (drq_en),
        .flush    (flush),
        .free     (CNTW'(DEPTH) - cnt),
        .trig_lvl (trig_lvl),
        .clr_cnt  (clr_cnt),
        .req      (dma_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            und_q <= 1'b0;
            lq    <= '0;
            rq    <= '0;
        end else begin
            stb_q <= tick;
            if (take) begin
                lq <= head0;
                rq <= mono ? head0 : head1;
            end else if (starve && !und_repeat) begin
                lq <= '0;
                rq <= '0;
            end
            if (starve) begin
                und_q <= 1'b1;
            end else if (und_clr) begin
                und_q <= 1'b0;
            end
        end
    end

    assign smp_stb   = stb_q;
    assign und_flag  = und_q;
    assign left_smp  = lq;
    assign right_smp = rq;
    assign fill      = cnt;
endmodule

// File: rtl/codec_tx_fifo_chk.sv
module codec_tx_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CNTW = $clog2(DEPTH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            drq_en,
    input logic            dma_req,
    input logic            play_en,
    input logic            smp_stb,
    input logic            mono,
    input logic            und_repeat,
    input logic [23:0]     left_smp,
    input logic [23:0]     right_smp,
    input logic [CNTW-1:0] fill
);
    p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNTW'(DEPTH));

    p_fill_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, fill} <= {1'b0, $past(fill)} + 1'b1));

    p_flush_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0));

    p_req_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !drq_en |=> !dma_req);

    p_stb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !smp_stb);

    p_mono_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (play_en && mono && !und_repeat) |=> (!smp_stb || (left_smp == right_smp)));
endmodule

bind codec_tx_fifo codec_tx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .drq_en     (drq_en),
    .dma_req    (dma_req),
    .play_en    (play_en),
    .smp_stb    (smp_stb),
    .mono       (mono),
    .und_repeat (und_repeat),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .fill       (fill)
);

// File: tb/codec_tx_fifo_tb_top.sv
module codec_tx_fifo_tb_top;
    localparam int DEPTH = 64;
    localparam int BASE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        flush = 1'b0;
    logic        drq_en = 1'b0;
    logic [5:0]  trig_lvl = 6'd15;
    logic [1:0]  clr_cnt = 2'd3;
    logic        wide_smp = 1'b0;
    logic        msb_rep = 1'b0;
    logic        und_repeat = 1'b0;
    logic        mono = 1'b0;
    logic [2:0]  rate_code = 3'd0;
    logic        play_en = 1'b0;
    logic        und_clr = 1'b0;
    logic        dma_req;
    logic        smp_stb;
    logic [23:0] left_smp;
    logic [23:0] right_smp;
    logic [6:0]  fill;
    logic        und_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    codec_tx_fifo #(.DEPTH(DEPTH), .BASE_DIV(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flush(flush), .drq_en(drq_en), .trig_lvl(trig_lvl), .clr_cnt(clr_cnt),
        .wide_smp(wide_smp), .msb_rep(msb_rep), .und_repeat(und_repeat),
        .mono(mono), .rate_code(rate_code), .play_en(play_en), .und_clr(und_clr),
        .dma_req(dma_req), .smp_stb(smp_stb), .left_smp(left_smp),
        .right_smp(right_smp), .fill(fill), .und_flag(und_flag)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic wait_stb();
        int guard = 0;
        @(negedge clk);
        while (!smp_stb && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        check(fill == 0, "R10 reset fill", fill, 0);
        check(!dma_req && !smp_stb && !und_flag, "R2 reset outputs",
              {dma_req, smp_stb, und_flag}, 0);
    endtask

    task automatic t_pack16();
        play_en = 0; mono = 0; wide_smp = 0; msb_rep = 1;
        do_flush();
        check(fill == 0, "R1 flush empties", fill, 0);
        push_word(32'hFFFF_8001);
        push_word(32'h0000_1234);
        check(fill == 2, "R10 fill after two writes", fill, 2);
        play_en = 1;
        wait_stb();
        check(left_smp == 24'h8001FF, "R4 msb repeat left", left_smp, 24'h8001FF);
        check(right_smp == 24'h123400, "R6 stereo right", right_smp, 24'h123400);
        check(fill == 0, "R6 stereo pops two", fill, 0);
        play_en = 0; msb_rep = 0;
        idle(2);
        push_word(32'h0000_8001);
        push_word(32'h0000_7FFF);
        play_en = 1;
        wait_stb();
        check(left_smp == 24'h800100, "R4 zero pad left", left_smp, 24'h800100);
        check(right_smp == 24'h7FFF00, "R4 zero pad right", right_smp, 24'h7FFF00);
        play_en = 0;
        idle(2);
    endtask

    task automatic t_pack24();
        wide_smp = 1; msb_rep = 1;
        push_word(32'hABCD_EF55);
        push_word(32'h0102_0399);
        play_en = 1;
        wait_stb();
        check(left_smp == 24'hABCDEF, "R5 wide left", left_smp, 24'hABCDEF);
        check(right_smp == 24'h010203, "R5 wide right", right_smp, 24'h010203);
        play_en = 0; wide_smp = 0; msb_rep = 0;
        idle(2);
    endtask

    task automatic t_mono();
        mono = 1;
        push_word(32'h0000_1111);
        push_word(32'h0000_2222);
        play_en = 1;
        wait_stb();
        check(left_smp == 24'h111100 && right_smp == 24'h111100, "R6 mono first",
              {left_smp, right_smp}, {24'h111100, 24'h111100});
        check(fill == 1, "R6 mono pops one", fill, 1);
        wait_stb();
        check(left_smp == 24'h222200 && right_smp == 24'h222200, "R6 mono second",
              {left_smp, right_smp}, {24'h222200, 24'h222200});
        play_en = 0; mono = 0;
        idle(2);
    endtask

    task automatic t_underrun();
        und_repeat = 0;
        do_flush();
        play_en = 1;
        wait_stb();
        check(left_smp == 0 && right_smp == 0, "R7 zeros on underrun",
              {left_smp, right_smp}, 0);
        check(und_flag == 1, "R7 flag set", und_flag, 1);
        play_en = 0;
        idle(2);
        @(negedge clk); und_clr = 1;
        @(negedge clk); und_clr = 0;
        check(und_flag == 0, "R7 flag cleared", und_flag, 0);
        und_repeat = 1;
        push_word(32'h0000_0AAA);
        push_word(32'h0000_0BBB);
        play_en = 1;
        wait_stb();
        check(left_smp == 24'h0AAA00 && right_smp == 24'h0BBB00, "R7 pair before hold",
              {left_smp, right_smp}, {24'h0AAA00, 24'h0BBB00});
        wait_stb();
        check(left_smp == 24'h0AAA00 && right_smp == 24'h0BBB00, "R7 hold last pair",
              {left_smp, right_smp}, {24'h0AAA00, 24'h0BBB00});
        play_en = 0;
        idle(2);
        push_word(32'h0000_0CCC);
        play_en = 1;
        wait_stb();
        check(fill == 1, "R7 lone stereo sample kept", fill, 1);
        check(left_smp == 24'h0AAA00, "R7 lone sample not sent", left_smp, 24'h0AAA00);
        play_en = 0; und_repeat = 0;
        idle(2);
        @(negedge clk); und_clr = 1;
        @(negedge clk); und_clr = 0;
        do_flush();
    endtask

    task automatic t_drq();
        drq_en = 0; trig_lvl = 6'd32; clr_cnt = 2'd3;
        for (int i = 0; i < 40; i++) push_word(i);
        drq_en = 1;
        idle(3);
        check(dma_req == 0, "R2 below trigger no request", dma_req, 0);
        @(negedge clk); flush = 1; wr_en = 1; wr_data = 32'h5;
        @(negedge clk); flush = 0; wr_en = 0;
        check(fill == 0, "R1 write dropped with flush", fill, 0);
        idle(2);
        check(dma_req == 1, "R1 request after flush", dma_req, 1);
        for (int i = 0; i < 48; i++) push_word(i);
        idle(2);
        check(dma_req == 1, "R2 free 16 keeps request", dma_req, 1);
        push_word(32'h1);
        idle(2);
        check(dma_req == 0, "R2 free 15 drops request", dma_req, 0);
        do_flush();
        idle(2);
        check(dma_req == 1, "R2 request raised again", dma_req, 1);
        for (int i = 0; i < 10; i++) push_word(i);
        @(negedge clk); drq_en = 0;
        idle(2);
        check(dma_req == 0, "R3 disable drops request", dma_req, 0);
        check(fill == 10, "R3 disable keeps data", fill, 10);
        do_flush();
    endtask

    task automatic t_full();
        for (int i = 0; i < 70; i++) push_word(i);
        check(fill == DEPTH, "R9 full drops extra writes", fill, DEPTH);
        do_flush();
    endtask

    task automatic measure(input logic [2:0] code, input int exp);
        int n = 0;
        rate_code = code;
        play_en = 1;
        wait_stb();
        wait_stb();
        @(negedge clk);
        n = 1;
        while (!smp_stb && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n == exp, "R8 strobe period", n, exp);
        play_en = 0;
        idle(2);
    endtask

    task automatic t_rate();
        int seen = 0;
        measure(3'd0, BASE);
        measure(3'd5, BASE * 6);
        measure(3'd6, BASE / 4);
        rate_code = 3'd0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (smp_stb) seen++;
        end
        check(seen == 0, "R8 no strobe when stopped", seen, 0);
        @(negedge clk); und_clr = 1;
        @(negedge clk); und_clr = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pack16();
        t_pack24();
        t_mono();
        t_underrun();
        t_drq();
        t_full();
        t_rate();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule